// File: doc/BRIEF.md
# Double-Buffered Bulk OUT Receive Buffer

This block holds received data for one bulk OUT endpoint in two storage halves, each one maximum packet long, so the total storage is twice the packet size. The receive engine pushes bytes of an incoming packet into whichever half is next in turn. When the packet ends cleanly, that half is marked occupied and its byte count is latched. A packet that ends with an error is thrown away, and its half stays free.

The consumer is firmware or a byte-wide DMA channel. It sees a full indication and the byte count of the oldest occupied half, and pulls that half out one byte per read strobe. When it has finished, it pulses a release input. The half then becomes free again, and the read side moves on to the other half. While both halves are occupied, a not-ready output tells the receive engine to refuse further data. A clear input empties the whole buffer at once.

Top module: `pp_rx_fifo`

## Requirements
- R1: After reset, `full_flag` is 0, `rx_count` is 0 and `nak` is 0.
- R2: A packet of N bytes, given as N cycles of `wr_valid` followed by a one-cycle `pkt_end`, makes `full_flag` 1 and `rx_count` equal to N from the clock edge that samples `pkt_end`, when no packet is already waiting to be read.
- R3: While `full_flag` is 1, `rd_data` shows the byte at the current read position. Each cycle with `rd_en` high moves the read position on by one. Bytes come out in the order they were received.
- R4: A `rd_done` pulse while `full_flag` is 1 frees the half being read. If the other half holds a packet, `full_flag` stays 1 and `rx_count` shows that packet's count. Otherwise `full_flag` drops to 0 and `rx_count` to 0.
- R5: Whenever the read side moves to the other half, reading restarts at byte 0 of that half.
- R6: Halves are filled strictly in turn and read in the same order, so two packets can wait at once and come out oldest first.
- R7: `nak` is 1 exactly while both halves are occupied. While it is 1, bytes and `pkt_end` are ignored. The held packets and counts are not changed.
- R8: A one-cycle `pkt_err` discards the bytes collected so far. The half stays free, and the next packet fills it starting from byte 0.
- R9: A `fifo_clr` pulse empties both halves and resets both pointers. `full_flag`, `rx_count` and `nak` are 0 after the edge. `fifo_clr` has priority over every other input in that cycle.
- R10: Bytes after the first `PKT_MAX` of one packet are dropped, and the latched count stops at `PKT_MAX` (64 by default).
- R11: `rd_done` or `rd_en` while `full_flag` is 0 has no effect. The next packet is still read from its byte 0 and counted correctly.
- R12: A `pkt_end` with no bytes before it stores a zero-length packet: `full_flag` is 1 and `rx_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Received byte strobe |
| wr_data | input | DATA_W | Received byte |
| pkt_end | input | 1 | Packet finished without error |
| pkt_err | input | 1 | Packet finished with error, discard it |
| rd_en | input | 1 | Byte read strobe, advances the read position |
| rd_data | output | DATA_W | Byte at the read position of the current half |
| rd_done | input | 1 | Read-finished trigger, frees the current half |
| fifo_clr | input | 1 | Empties both halves |
| full_flag | output | 1 | The current read half holds a packet |
| rx_count | output | CNT_W | Byte count of the packet in the current read half |
| nak | output | 1 | Both halves occupied, reception refused |

## Verification
A write-select bit or read-select bit that slips out of step shows on the next packet. Either `rx_count` reports a stale or zero count, or `rd_data` returns the other half's bytes at position 0. A stuck occupancy bit shows as `nak` remaining 1, or `full_flag` remaining 0, one cycle after the release or commit edge that should have changed it. A read pointer that is not rewound shows as a wrong first byte after the first release. Each two-packet and discard scenario is therefore followed by a full read-back of the next packet.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;
  typedef enum logic [1:0] {
    PE_IDLE   = 2'd0,
    PE_COMMIT = 2'd1,
    PE_ABORT  = 2'd2
  } pkt_evt_e;
endpackage

// File: rtl/pp_half_buf.sv
module pp_half_buf #(
  parameter int unsigned PKT_MAX = 64,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned AW     = $clog2(PKT_MAX)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [PKT_MAX];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pp_wr_ctrl.sv
module pp_wr_ctrl
  import pp_rx_pkg::*;
#(
  parameter int unsigned PKT_MAX = 64,
  localparam int unsigned CNT_W  = $clog2(PKT_MAX + 1),
  localparam int unsigned AW     = $clog2(PKT_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_valid_i,
  input  logic             pkt_end_i,
  input  logic             pkt_err_i,
  input  logic [1:0]       half_busy_i,
  output logic             wsel_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             commit_o,
  output logic [CNT_W-1:0] commit_len_o
);
  logic             wsel_q, wsel_d;
  logic [CNT_W-1:0] wcnt_q, wcnt_d;
  logic             half_taken;
  logic             room;
  logic             byte_ok;
  pkt_evt_e         evt;

  always_comb begin
    half_taken = half_busy_i[wsel_q];
    room       = (wcnt_q < CNT_W'(PKT_MAX));
    evt        = PE_IDLE;
    if (!clr_i) begin
      if (pkt_err_i) begin
        evt = PE_ABORT;
      end else if (pkt_end_i && !half_taken) begin
        evt = PE_COMMIT;
      end
    end
    byte_ok = wr_valid_i && !clr_i && !pkt_err_i && !pkt_end_i && !half_taken && room;
  end

  always_comb begin
    wsel_d = wsel_q;
    wcnt_d = wcnt_q;
    if (clr_i) begin
      wsel_d = 1'b0;
      wcnt_d = '0;
    end else begin
      case (evt)
        PE_ABORT: begin
          wcnt_d = '0;
        end
        PE_COMMIT: begin
          wcnt_d = '0;
          wsel_d = ~wsel_q;
        end
        default: begin
          if (byte_ok) begin
            wcnt_d = wcnt_q + CNT_W'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q <= 1'b0;
      wcnt_q <= '0;
    end else begin
      wsel_q <= wsel_d;
      wcnt_q <= wcnt_d;
    end
  end

  assign wsel_o       = wsel_q;
  assign mem_we_o     = byte_ok;
  assign mem_addr_o   = wcnt_q[AW-1:0];
  assign commit_o     = (evt == PE_COMMIT);
  assign commit_len_o = wcnt_q;

  // R8
  abort_rewinds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_err_i && !clr_i) |=> (wcnt_q == '0));

  // R10
  wcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= CNT_W'(PKT_MAX));
endmodule

// File: rtl/pp_rd_ctrl.sv
module pp_rd_ctrl #(
  parameter int unsigned PKT_MAX = 64,
  localparam int unsigned AW     = $clog2(PKT_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          rd_en_i,
  input  logic          rd_done_i,
  input  logic [1:0]    half_busy_i,
  output logic          rsel_o,
  output logic [AW-1:0] rptr_o,
  output logic [1:0]    release_o
);
  logic          rsel_q, rsel_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic          cur_full;
  logic          rel;
  logic          step;

  always_comb begin
    cur_full = half_busy_i[rsel_q];
    rel      = rd_done_i && cur_full && !clr_i;
    step     = rd_en_i && cur_full && !rel && !clr_i;
  end

  always_comb begin
    rsel_d = rsel_q;
    rptr_d = rptr_q;
    if (clr_i) begin
      rsel_d = 1'b0;
      rptr_d = '0;
    end else if (rel) begin
      rsel_d = ~rsel_q;
      rptr_d = '0;
    end else if (step) begin
      rptr_d = rptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q <= 1'b0;
      rptr_q <= '0;
    end else begin
      rsel_q <= rsel_d;
      rptr_q <= rptr_d;
    end
  end

  assign rsel_o    = rsel_q;
  assign rptr_o    = rptr_q;
  assign release_o = {rel && rsel_q, rel && !rsel_q};

  // R5
  rptr_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done_i && half_busy_i[rsel_q]) |=> (rptr_q == '0));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_busy_i[rsel_q] && !clr_i) |=> ($stable(rsel_q) && $stable(rptr_q)));
endmodule

// File: rtl/pp_occupancy.sv
module pp_occupancy #(
  parameter int unsigned PKT_MAX = 64,
  localparam int unsigned CNT_W  = $clog2(PKT_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  commit_i,
  input  logic                  commit_half_i,
  input  logic [CNT_W-1:0]      commit_len_i,
  input  logic [1:0]            release_i,
  output logic [1:0]            busy_o,
  output logic [1:0][CNT_W-1:0] len_o
);
  logic [1:0] busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (clr_i) begin
      busy_d = 2'b00;
    end else begin
      busy_d = busy_q & ~release_i;
      if (commit_i) begin
        busy_d[commit_half_i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 2'b00;
    end else begin
      busy_q <= busy_d;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_len
    logic [CNT_W-1:0] len_q, len_d;
    logic             len_en;

    always_comb begin
      len_en = commit_i && !clr_i && (commit_half_i == 1'(h));
      len_d  = len_en ? commit_len_i : len_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q <= '0;
      end else begin
        len_q <= len_d;
      end
    end

    assign len_o[h] = len_q;
  end

  assign busy_o = busy_q;

  // R7
  no_double_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> !busy_q[commit_half_i]);

  // R4
  release_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((release_i & ~busy_q) == 2'b00));
endmodule

// File: rtl/pp_rx_fifo.sv
module pp_rx_fifo #(
  parameter int unsigned PKT_MAX = 64,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned CNT_W  = $clog2(PKT_MAX + 1),
  localparam int unsigned AW     = $clog2(PKT_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pkt_end,
  input  logic              pkt_err,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_done,
  input  logic              fifo_clr,
  output logic              full_flag,
  output logic [CNT_W-1:0]  rx_count,
  output logic              nak
);
  logic [1:0]            busy;
  logic [1:0][CNT_W-1:0] len;
  logic                  wsel;
  logic                  mem_we;
  logic [AW-1:0]         mem_addr;
  logic                  commit;
  logic [CNT_W-1:0]      commit_len;
  logic                  rsel;
  logic [AW-1:0]         rptr;
  logic [1:0]            release_v;
  logic [DATA_W-1:0]     half_rdata [2];

  pp_wr_ctrl #(.PKT_MAX(PKT_MAX)) u_wr (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (fifo_clr),
    .wr_valid_i   (wr_valid),
    .pkt_end_i    (pkt_end),
    .pkt_err_i    (pkt_err),
    .half_busy_i  (busy),
    .wsel_o       (wsel),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .commit_o     (commit),
    .commit_len_o (commit_len)
  );

  pp_rd_ctrl #(.PKT_MAX(PKT_MAX)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (fifo_clr),
    .rd_en_i     (rd_en),
    .rd_done_i   (rd_done),
    .half_busy_i (busy),
    .rsel_o      (rsel),
    .rptr_o      (rptr),
    .release_o   (release_v)
  );

  pp_occupancy #(.PKT_MAX(PKT_MAX)) u_occ (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_i         (fifo_clr),
    .commit_i      (commit),
    .commit_half_i (wsel),
    .commit_len_i  (commit_len),
    .release_i     (release_v),
    .busy_o        (busy),
    .len_o         (len)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic half_we;
    assign half_we = mem_we && (wsel == 1'(h));

    pp_half_buf #(.PKT_MAX(PKT_MAX), .DATA_W(DATA_W)) u_buf (
      .clk     (clk),
      .we_i    (half_we),
      .waddr_i (mem_addr),
      .wdata_i (wr_data),
      .raddr_i (rptr),
      .rdata_o (half_rdata[h])
    );
  end

  always_comb begin
    full_flag = busy[rsel];
    rx_count  = busy[rsel] ? len[rsel] : '0;
    rd_data   = half_rdata[rsel];
    nak       = &busy;
  end

  // R6
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy == 2'b00) || (busy == 2'b11)) |-> (wsel == rsel));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (!full_flag && !nak && (rx_count == '0)));

  // R4
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_flag) |-> ($past(rd_done) || $past(fifo_clr)));

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(PKT_MAX));
endmodule

// File: tb/sim_pp_rx_fifo.sv
module sim_pp_rx_fifo;
  localparam int PKT_MAX = 64;
  localparam int NV = 5;
  localparam int VLEN [NV] = '{1, 5, 64, 17, 33};
  localparam int VSEED[NV] = '{8'h11, 8'h5A, 8'h00, 8'hC3, 8'h7E};

  logic       clk;
  logic       rst_n;
  logic       wr_valid;
  logic [7:0] wr_data;
  logic       pkt_end;
  logic       pkt_err;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       rd_done;
  logic       fifo_clr;
  logic       full_flag;
  logic [6:0] rx_count;
  logic       nak;

  int total;
  int failed;

  pp_rx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .pkt_end(pkt_end), .pkt_err(pkt_err), .rd_en(rd_en), .rd_data(rd_data),
    .rd_done(rd_done), .fifo_clr(fifo_clr), .full_flag(full_flag),
    .rx_count(rx_count), .nak(nak)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed + i * 3);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bytes(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = pat(seed, i);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic send_pkt(input int len, input int seed);
    send_bytes(len, seed);
    pkt_end = 1'b1;
    @(negedge clk);
    pkt_end = 1'b0;
  endtask

  task automatic read_pkt(input string req, input int len, input int seed);
    int bad;
    bad = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (rd_data != pat(seed, i)) begin
        if (bad == 0) check(req, int'(rd_data), int'(pat(seed, i)));
        bad++;
      end
      rd_en = 1'b1;
    end
    @(negedge clk);
    rd_en = 1'b0;
    if (bad == 0) check(req, 0, 0);
  endtask

  task automatic release_half();
    @(negedge clk);
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end

  initial begin
    total = 0; failed = 0;
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; pkt_end = 1'b0; pkt_err = 1'b0;
    rd_en = 1'b0; rd_done = 1'b0; fifo_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 full", int'(full_flag), 0);
    check("R1 count", int'(rx_count), 0);
    check("R1 nak", int'(nak), 0);

    // R2 R3 R4 R5: table walk of single packets
    for (int v = 0; v < NV; v++) begin
      send_pkt(VLEN[v], VSEED[v]);
      check("R2 full", int'(full_flag), 1);
      check("R2 count", int'(rx_count), VLEN[v]);
      check("R7 nak one half", int'(nak), 0);
      read_pkt("R3 data", VLEN[v], VSEED[v]);
      release_half();
      check("R4 flag clears", int'(full_flag), 0);
      check("R4 count clears", int'(rx_count), 0);
    end

    // R6 R7: two packets waiting, third refused
    send_pkt(3, 8'h10);
    send_pkt(4, 8'h40);
    check("R7 nak both", int'(nak), 1);
    check("R6 oldest count", int'(rx_count), 3);
    send_pkt(2, 8'h80);
    check("R7 ignored count", int'(rx_count), 3);
    check("R7 nak held", int'(nak), 1);
    read_pkt("R6 first data", 3, 8'h10);
    release_half();
    check("R4 switch flag", int'(full_flag), 1);
    check("R4 switch count", int'(rx_count), 4);
    check("R7 nak drops", int'(nak), 0);
    read_pkt("R5 second data from 0", 4, 8'h40);
    release_half();
    check("R7 third not stored", int'(full_flag), 0);

    // R8: discard on error
    send_bytes(5, 8'h99);
    pkt_err = 1'b1;
    @(negedge clk);
    pkt_err = 1'b0;
    check("R8 no flag", int'(full_flag), 0);
    send_pkt(2, 8'h20);
    check("R8 count", int'(rx_count), 2);
    read_pkt("R8 data", 2, 8'h20);
    release_half();

    // R10: oversize packet
    send_pkt(70, 8'h33);
    check("R10 count", int'(rx_count), PKT_MAX);
    read_pkt("R10 data", PKT_MAX, 8'h33);
    release_half();

    // R11: stray release and read while empty
    release_half();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check("R11 still empty", int'(full_flag), 0);
    send_pkt(3, 8'hA0);
    check("R11 count", int'(rx_count), 3);
    read_pkt("R11 data", 3, 8'hA0);
    release_half();
    check("R11 flag clears", int'(full_flag), 0);

    // R9: clear with both halves occupied, clear wins over release
    send_pkt(6, 8'h01);
    send_pkt(7, 8'h02);
    check("R9 nak before", int'(nak), 1);
    @(negedge clk);
    fifo_clr = 1'b1; rd_done = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0; rd_done = 1'b0;
    check("R9 full", int'(full_flag), 0);
    check("R9 nak", int'(nak), 0);
    check("R9 count", int'(rx_count), 0);
    send_pkt(2, 8'h77);
    check("R9 count after", int'(rx_count), 2);
    read_pkt("R9 data after", 2, 8'h77);
    release_half();

    // R12: zero-length packet
    send_pkt(0, 0);
    check("R12 full", int'(full_flag), 1);
    check("R12 count", int'(rx_count), 0);
    release_half();
    check("R12 released", int'(full_flag), 0);

    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end
endmodule